// File: doc/BRIEF.md
# Teletype Serial Character Transmitter

This block turns an 8-bit character written over a simple programmed-I/O bus into an asynchronous serial frame for a teletype line. A device-select strobe places the character in a holding register. The block then sends a space start bit, the eight data bits with the least significant bit first, and a mark stop period. The stop period is 1, 1.5 or 2 bit times, chosen by a 2-bit setting that is captured together with the character. The line rests at mark whenever no character is being sent.

All timing comes from `half_tick`. This is a one-cycle strobe in the system clock domain that arrives at twice the baud rate. Every bit occupies two strobe intervals. Because the unit of time is half a bit, a stop period of one and a half bits can be produced exactly.

When a frame ends, the block raises a done flag. The flag drives a skip output, and an interrupt request when interrupts are enabled. Software can clear the flag, and a bus-wide clear abandons any frame in progress.

Top module: `ttx_char_tx`

## Requirements
- R1: While reset is active and after it is released, the line output is mark (1), and the done flag, active, skip and interrupt outputs are all 0.
- R2: A load strobe that is accepted while the block is idle captures `dev_data`. Starting at the next `half_tick`, the line carries a start bit of space (0) lasting two half-bit intervals, then data bits 0 through 7 in that order, each lasting two half-bit intervals.
- R3: `stop_sel` is captured when the load is accepted. The stop period is mark and lasts 2 half-bit intervals for code 00, 3 for code 01, and 4 for codes 10 and 11. Changing `stop_sel` after the load has no effect on that frame.
- R4: The line output changes only in the cycle after a `half_tick` strobe or a bus clear.
- R5: `tx_active` rises on the first `half_tick` after an accepted load and falls on the `half_tick` that follows the final stop interval. The done flag sets on that same edge. A frame therefore stays active for (18 + stop intervals) strobe periods.
- R6: A load strobe that arrives between the accepted load and the end of its frame is ignored. The frame keeps the captured data and stop length.
- R7: `skip` equals the done flag. `irq` equals the done flag ANDed with `int_en`.
- R8: `flag_clr` clears the done flag, and so does an accepted load. If the flag is set on the same edge as `flag_clr`, the set wins.
- R9: `io_clr` returns the line to mark and clears the done flag, the active state and any pending or in-progress character on the next edge. A load that coincides with `io_clr` is ignored.
- R10: Whenever no frame is active, the line output is mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_tick | input | 1 | One-cycle strobe at twice the baud rate |
| dev_load | input | 1 | Device-select load strobe |
| dev_data | input | 8 | Character from the bus data lines |
| stop_sel | input | 2 | Stop length code: 00 = 1 bit, 01 = 1.5 bits, 10 or 11 = 2 bits |
| flag_clr | input | 1 | Clear the done flag |
| io_clr | input | 1 | Bus-wide clear |
| int_en | input | 1 | Interrupt enable |
| line_out | output | 1 | Serial line; 1 = mark, 0 = space |
| done_flag | output | 1 | Character completed |
| tx_active | output | 1 | Frame on the line |
| skip | output | 1 | Skip condition for the bus |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `half_tick` is a single-cycle pulse and that consecutive pulses are at least two clock cycles apart. Without that spacing, the claim that line changes follow only strobes would say nothing about bit widths. They also assume that bus strobes are synchronous to `clk`. The stimulus generates `half_tick` from a divide-by-four counter, and it drives every bus input one time unit after the rising edge. This keeps each strobe clean and far from the sampling edge.

// File: rtl/ttx_pkg.sv
package ttx_pkg;

  typedef enum logic [1:0] {
    STOP_ONE      = 2'b00,
    STOP_ONE_HALF = 2'b01,
    STOP_TWO      = 2'b10,
    STOP_TWO_ALT  = 2'b11
  } stop_code_e;

  // Stop period length in half-bit intervals.
  function automatic int unsigned stop_halves(input logic [1:0] code);
    case (stop_code_e'(code))
      STOP_ONE:      stop_halves = 2;
      STOP_ONE_HALF: stop_halves = 3;
      default:       stop_halves = 4;
    endcase
  endfunction

endpackage

// File: rtl/ttx_frame_seq.sv
module ttx_frame_seq import ttx_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int POS_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             half_tick,
  input  logic             load_req,
  input  logic             io_clr,
  input  logic [1:0]       stop_sel,
  output logic             load_acc,
  output logic             busy,
  output logic             active,
  output logic             frame_done,
  output logic [POS_W-1:0] pos
);

  localparam int BODY_HALVES = 2 * (DATA_W + 1);

  logic             busy_q, busy_d;
  logic             active_q, active_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic [1:0]       stop_q, stop_d;
  logic [POS_W-1:0] last_pos;
  logic             at_last;

  always_comb begin
    last_pos   = POS_W'(BODY_HALVES + int'(stop_halves(stop_q)) - 1);
    at_last    = (pos_q == last_pos);
    load_acc   = load_req && !busy_q && !io_clr;
    frame_done = busy_q && active_q && half_tick && at_last && !io_clr;
  end

  always_comb begin
    busy_d   = busy_q;
    active_d = active_q;
    pos_d    = pos_q;
    stop_d   = stop_q;
    if (io_clr) begin
      busy_d   = 1'b0;
      active_d = 1'b0;
      pos_d    = '0;
    end else begin
      if (half_tick && busy_q) begin
        if (!active_q) begin
          active_d = 1'b1;
          pos_d    = '0;
        end else if (at_last) begin
          active_d = 1'b0;
          busy_d   = 1'b0;
          pos_d    = '0;
        end else begin
          pos_d = pos_q + POS_W'(1);
        end
      end
      if (load_acc) begin
        busy_d = 1'b1;
        stop_d = stop_sel;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      active_q <= 1'b0;
      pos_q    <= '0;
      stop_q   <= 2'b00;
    end else begin
      busy_q   <= busy_d;
      active_q <= active_d;
      pos_q    <= pos_d;
      stop_q   <= stop_d;
    end
  end

  assign busy   = busy_q;
  assign active = active_q;
  assign pos    = pos_q;

  // R5
  active_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> busy_q);

  // R3
  pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (pos_q <= POS_W'(BODY_HALVES + 3)));

  // R9
  io_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_clr |=> (!busy_q && !active_q));

  // R6
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(stop_q));

endmodule

// File: rtl/ttx_shifter.sv
module ttx_shifter #(
  parameter int DATA_W = 8,
  parameter int POS_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_acc,
  input  logic [DATA_W-1:0] data_in,
  input  logic              busy,
  input  logic              active,
  input  logic [POS_W-1:0]  pos,
  output logic              line
);

  localparam int IDX_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int DATA_END = 2 + 2 * DATA_W;

  logic [DATA_W-1:0] hold_q, hold_d;
  logic [IDX_W-1:0]  bit_sel;

  always_comb begin
    hold_d = hold_q;
    if (load_acc) hold_d = data_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  always_comb begin
    bit_sel = IDX_W'((pos - POS_W'(2)) >> 1);
    line    = 1'b1;
    if (active) begin
      if (pos < POS_W'(2))             line = 1'b0;
      else if (pos < POS_W'(DATA_END)) line = hold_q[bit_sel];
    end
  end

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(hold_q));

endmodule

// File: rtl/ttx_flags.sv
module ttx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_done,
  input  logic load_acc,
  input  logic flag_clr,
  input  logic io_clr,
  input  logic int_en,
  output logic flag,
  output logic skip,
  output logic irq
);

  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (flag_clr || load_acc) flag_d = 1'b0;
    if (frame_done)           flag_d = 1'b1;
    if (io_clr)               flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
  assign skip = flag_q;
  assign irq  = flag_q && int_en;

  // R5
  flag_set_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(frame_done));

  // R8
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && flag_clr && !io_clr) |=> flag_q);

endmodule

// File: rtl/ttx_char_tx.sv
module ttx_char_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_tick,
  input  logic              dev_load,
  input  logic [DATA_W-1:0] dev_data,
  input  logic [1:0]        stop_sel,
  input  logic              flag_clr,
  input  logic              io_clr,
  input  logic              int_en,
  output logic              line_out,
  output logic              done_flag,
  output logic              tx_active,
  output logic              skip,
  output logic              irq
);

  localparam int MAX_HALVES = 2 * (DATA_W + 1) + 4;
  localparam int POS_W      = $clog2(MAX_HALVES);

  logic [1:0]       rst_sync_q;
  logic             rst_n_int;
  logic             load_acc, busy, active, frame_done;
  logic [POS_W-1:0] pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  ttx_frame_seq #(.DATA_W(DATA_W), .POS_W(POS_W)) seq_i (
    .clk(clk), .rst_n(rst_n_int), .half_tick(half_tick), .load_req(dev_load),
    .io_clr(io_clr), .stop_sel(stop_sel), .load_acc(load_acc), .busy(busy),
    .active(active), .frame_done(frame_done), .pos(pos));

  ttx_shifter #(.DATA_W(DATA_W), .POS_W(POS_W)) shift_i (
    .clk(clk), .rst_n(rst_n_int), .load_acc(load_acc), .data_in(dev_data),
    .busy(busy), .active(active), .pos(pos), .line(line_out));

  ttx_flags flags_i (
    .clk(clk), .rst_n(rst_n_int), .frame_done(frame_done), .load_acc(load_acc),
    .flag_clr(flag_clr), .io_clr(io_clr), .int_en(int_en), .flag(done_flag),
    .skip(skip), .irq(irq));

  assign tx_active = active;

  // R4
  line_change_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !$stable(line_out) |-> ($past(half_tick) || $past(io_clr)));

  // R10
  idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !busy |-> line_out);

  // R7
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    irq |-> (skip && int_en));

endmodule

// File: tb/ttx_char_tx_tb.sv
module ttx_char_tx_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       half_tick = 1'b0;
  logic       dev_load = 1'b0;
  logic [7:0] dev_data = 8'h00;
  logic [1:0] stop_sel = 2'b00;
  logic       flag_clr = 1'b0;
  logic       io_clr = 1'b0;
  logic       int_en = 1'b0;
  logic       line_out, done_flag, tx_active, skip, irq;

  int errors = 0;
  int checks = 0;
  int act_cnt = 0;
  int div_cnt = 0;

  // Reference model state
  bit m_busy = 0, m_active = 0, m_flag = 0, m_line = 1;
  bit m_q[$];

  always #5 clk = ~clk;

  ttx_char_tx dut_i (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .dev_load(dev_load),
    .dev_data(dev_data), .stop_sel(stop_sel), .flag_clr(flag_clr), .io_clr(io_clr),
    .int_en(int_en), .line_out(line_out), .done_flag(done_flag), .tx_active(tx_active),
    .skip(skip), .irq(irq));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Strobe at twice the baud rate: one cycle in four.
  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      div_cnt   = 0;
      half_tick = 1'b0;
    end else begin
      div_cnt   = (div_cnt + 1) % 4;
      half_tick = (div_cnt == 0);
    end
  end

  // Behavioural reference: a queue of half-bit line levels per frame.
  always @(posedge clk) begin
    bit acc, end_now;
    int sh;
    if (!rst_n) begin
      m_busy = 0; m_active = 0; m_flag = 0; m_line = 1; m_q.delete();
    end else begin
      acc     = dev_load && !m_busy && !io_clr;
      end_now = 0;
      if (io_clr) begin
        m_busy = 0; m_active = 0; m_flag = 0; m_line = 1; m_q.delete();
      end else begin
        if (half_tick && m_busy) begin
          if (m_q.size() > 0) begin
            m_line   = m_q.pop_front();
            m_active = 1;
          end else begin
            m_busy = 0; m_active = 0; m_line = 1; end_now = 1;
          end
        end
        if (flag_clr) m_flag = 0;
        if (acc) begin
          m_flag = 0;
          m_busy = 1;
          sh = (stop_sel == 2'b00) ? 2 : (stop_sel == 2'b01) ? 3 : 4;
          m_q.push_back(1'b0); m_q.push_back(1'b0);
          for (int i = 0; i < 8; i++) begin
            m_q.push_back(dev_data[i]); m_q.push_back(dev_data[i]);
          end
          for (int i = 0; i < sh; i++) m_q.push_back(1'b1);
        end
        if (end_now) m_flag = 1;
      end
    end
  end

  // Compare outputs to the model on every cycle.
  always @(negedge clk) begin
    if (rst_n) begin
      chk(line_out == m_line, "R2 R3 R10 line", line_out, m_line);
      chk(done_flag == m_flag, "R5 R8 flag", done_flag, m_flag);
      chk(tx_active == m_active, "R5 active", tx_active, m_active);
      chk(skip == m_flag, "R7 skip", skip, m_flag);
      chk(irq == (m_flag && int_en), "R7 irq", irq, m_flag && int_en);
      if (tx_active) act_cnt++;
    end
  end

  task automatic load(input logic [7:0] d, input logic [1:0] s);
    @(posedge clk); #1;
    dev_load = 1'b1; dev_data = d; stop_sel = s;
    @(posedge clk); #1;
    dev_load = 1'b0; stop_sel = ~s;
    act_cnt = 0;
  endtask

  task automatic wait_flag();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (done_flag) break;
    end
  endtask

  task automatic frame(input logic [7:0] d, input logic [1:0] s, input int halves);
    load(d, s);
    wait_flag();
    chk(done_flag == 1'b1, "R5 flag after frame", done_flag, 1);
    chk(act_cnt == halves * 4, "R3 active length", act_cnt, halves * 4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R5 watchdog expired: actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 during reset
    chk(line_out == 1'b1, "R1 line in reset", line_out, 1);
    chk(done_flag == 1'b0 && tx_active == 1'b0, "R1 status in reset", done_flag | tx_active, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(line_out == 1'b1 && skip == 1'b0 && irq == 1'b0, "R1 after reset", line_out, 1);

    // R2, R3 with each stop code
    frame(8'hA5, 2'b00, 20);
    chk(skip == 1'b1 && irq == 1'b0, "R7 skip without irq", irq, 0);
    @(posedge clk); #1 int_en = 1'b1;
    @(negedge clk);
    chk(irq == 1'b1, "R7 irq enabled", irq, 1);
    @(posedge clk); #1 flag_clr = 1'b1;
    @(posedge clk); #1 flag_clr = 1'b0;
    @(negedge clk);
    chk(done_flag == 1'b0, "R8 flag_clr", done_flag, 0);

    frame(8'h3C, 2'b01, 21);
    frame(8'h01, 2'b10, 22);
    frame(8'h80, 2'b11, 22);

    // R8: an accepted load clears the flag
    load(8'h5A, 2'b01);
    @(negedge clk);
    chk(done_flag == 1'b0, "R8 load clears flag", done_flag, 0);
    wait_flag();
    chk(act_cnt == 84, "R3 1.5 stop length", act_cnt, 84);

    // R6: load during a frame is ignored
    load(8'hC3, 2'b10);
    repeat (20) @(posedge clk);
    #1 dev_load = 1'b1; dev_data = 8'hFF; stop_sel = 2'b00;
    @(posedge clk); #1 dev_load = 1'b0;
    wait_flag();
    chk(act_cnt == 88, "R6 frame kept length", act_cnt, 88);

    // R8: flag_clr held across the end of a frame; the set wins
    load(8'h0F, 2'b00);
    flag_clr = 1'b1;
    begin
      bit seen = 0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (done_flag) seen = 1;
      end
      chk(seen, "R8 set beats clear", seen, 1);
    end
    @(posedge clk); #1 flag_clr = 1'b0;

    // R9: bus clear in mid-frame
    load(8'h55, 2'b10);
    repeat (30) @(posedge clk);
    #1 io_clr = 1'b1;
    @(posedge clk); #1 io_clr = 1'b0;
    @(negedge clk);
    chk(line_out == 1'b1 && tx_active == 1'b0 && done_flag == 1'b0,
        "R9 clear mid-frame", {line_out, tx_active, done_flag}, 3'b100);
    act_cnt = 0;
    repeat (120) @(negedge clk);
    chk(act_cnt == 0, "R9 frame abandoned", act_cnt, 0);

    // R9: load coinciding with io_clr is ignored
    @(posedge clk); #1;
    io_clr = 1'b1; dev_load = 1'b1; dev_data = 8'h00; stop_sel = 2'b00;
    @(posedge clk); #1 io_clr = 1'b0; dev_load = 1'b0;
    act_cnt = 0;
    repeat (120) @(negedge clk);
    chk(act_cnt == 0 && done_flag == 1'b0, "R9 load during clear", act_cnt, 0);

    // R4/R10: transmit again after clearing
    frame(8'h96, 2'b00, 20);
    repeat (10) @(negedge clk);
    chk(line_out == 1'b1, "R10 idle mark", line_out, 1);

    summary();
    $finish;
  end

endmodule